// File: doc/BRIEF.md
# Low-Power Stop Sequencer

This block is the system-controller state machine that takes the chip into a stop state and brings it back out. While the chip runs normally, it watches a 2-bit power-mode selection and the processor's wait-for-interrupt indication. When both call for a stop, it walks a fixed chain of request/acknowledge handshakes:

- drain the AHB bus;
- drain the AXI bus;
- put external memory into self-refresh;
- move the system clock from the PLL to the oscillator;
- optionally gate power, in the deep variant;
- switch the PLL and the crystal oscillator off.

A single wake input undoes the chain in reverse. The oscillator comes up first, then power in the deep variant, then the PLL. Each of these waits for a programmable number of cycles. After that the sequencer restores the clock, drops its requests and, in the deep variant, releases the processor reset it held during wake-up.

The three wait lengths are plain register inputs. Each is captured when its wait step begins. A wake that arrives while the entry chain is still running is remembered, so no handshake is left half done. It takes effect the moment the stopped state is reached.

Top module: `lp_stop_seq`

## Requirements
- R1: While reset is applied and after it, all three requests are low, `pll_en` and `osc_en` are high, and `pwr_gate`, `cpu_rst_hold` and `clk_src_pll` are low. Reset assertion takes effect without waiting for a clock edge.
- R2: In the normal state the sequence starts only when `wfi_i` is high and `mode_sel` is 2'b01 (stop) or 2'b10 (deep stop). `ahb_drain_req` then rises on the next cycle. With `mode_sel` 2'b00 or 2'b11, `wfi_i` has no effect.
- R3: `axi_drain_req` stays low until `ahb_drain_ack` has been seen high. It rises one cycle after that.
- R4: `sref_req` stays low until `axi_drain_ack` has been seen high. It rises one cycle after that.
- R5: In the normal state `clk_src_pll` follows `pll_in_use` one cycle later (1 = PLL, 0 = oscillator). It keeps the captured value through the drain and self-refresh steps. It goes low one cycle after `sref_ack` is seen high.
- R6: In deep stop, `pwr_gate` rises one cycle after the clock switch, while the PLL is still on, and stays high while stopped. In plain stop, `pwr_gate` never rises.
- R7: One cycle after the clock switch (plain) or the power gate (deep), `pll_en` and `osc_en` go low. They stay low until the wake input is seen.
- R8: On wake, `osc_en` rises first. The oscillator wait keeps `pll_en` low for `osc_wait`+1 cycles.
- R9: In deep stop only, `cpu_rst_hold` is high from the first wake-up cycle onward. After the oscillator wait, `pwr_gate` drops and the power wait lasts `pwr_wait`+1 cycles. Plain stop has no power wait and never holds the reset.
- R10: Next, `pll_en` rises and the lock wait lasts `lock_wait`+1 cycles. Then comes one restore cycle: `clk_src_pll` returns to the captured PLL use, all requests are low, and `cpu_rst_hold` still equals the deep flag. On the following cycle `cpu_rst_hold` is low and the block is back in normal operation.
- R11: A wake pulse during the entry chain is remembered. The stopped state then lasts exactly one cycle before the oscillator comes up. A wake pulse in the normal state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Power mode: 01 stop, 10 deep stop, others normal |
| wfi_i | input | 1 | Processor waiting for interrupt |
| wake_i | input | 1 | Dedicated wake-up event |
| pll_in_use | input | 1 | System clock is currently taken from the PLL |
| osc_wait | input | CNT_W | Oscillator stabilisation cycles |
| pwr_wait | input | CNT_W | Power restore stabilisation cycles (deep stop) |
| lock_wait | input | CNT_W | PLL lock cycles |
| ahb_drain_req | output | 1 | Ask AHB controller to finish and hold |
| ahb_drain_ack | input | 1 | AHB controller idle |
| axi_drain_req | output | 1 | Ask AXI domain to finish and hold |
| axi_drain_ack | input | 1 | AXI domain idle |
| sref_req | output | 1 | Ask memory controllers to enter self-refresh |
| sref_ack | input | 1 | Memories in self-refresh |
| clk_src_pll | output | 1 | Clock mux select: 1 PLL, 0 oscillator |
| pwr_gate | output | 1 | Power-gate the switchable domains |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Crystal oscillator enable |
| cpu_rst_hold | output | 1 | Hold the processor in reset |

## Verification
The hardest situation to reach from the ports is a wake event that overlaps the entry chain. It must be neither lost nor able to cut a handshake short. The stimulus pulses the wake input while the AXI drain is still waiting for its acknowledge. It then completes the chain and checks two things: the stopped state lasts a single cycle, and the oscillator wait follows at once. The bench runs this in both plain and deep mode. The wait counters are covered from a table of mode and count combinations, including all-zero waits. For each combination the bench counts how many cycles each phase leaves its visible signature on the enables and gates.

// File: rtl/lp_stop_pkg.sv
package lp_stop_pkg;

  localparam logic [1:0] MODE_STOP = 2'b01;
  localparam logic [1:0] MODE_DEEP = 2'b10;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_AHB,
    ST_AXI,
    ST_SREF,
    ST_CLKSW,
    ST_PGATE,
    ST_OFF,
    ST_W_OSC,
    ST_W_PWR,
    ST_W_PLL,
    ST_RESTORE
  } seq_state_e;

  function automatic logic is_wait(seq_state_e s);
    return (s == ST_W_OSC) || (s == ST_W_PWR) || (s == ST_W_PLL);
  endfunction

  function automatic logic is_entry(seq_state_e s);
    return (s == ST_AHB) || (s == ST_AXI) || (s == ST_SREF) ||
           (s == ST_CLKSW) || (s == ST_PGATE);
  endfunction

endpackage

// File: rtl/lp_stop_cnt.sv
module lp_stop_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lp_stop_wake.sv
module lp_stop_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  logic pend_d, pend_en;

  assign pend_en = set | clr;
  assign pend_d  = set & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (pend_en) pend <= pend_d;
  end
endmodule

// File: rtl/lp_stop_outdec.sv
module lp_stop_outdec
  import lp_stop_pkg::*;
(
  input  seq_state_e state,
  input  logic       deep,
  input  logic       pll_used,
  output logic       ahb_req,
  output logic       axi_req,
  output logic       sref_req,
  output logic       clk_pll,
  output logic       pgate,
  output logic       pll_on,
  output logic       osc_on,
  output logic       rst_hold
);
  always_comb begin
    ahb_req  = 1'b0;
    axi_req  = 1'b0;
    sref_req = 1'b0;
    clk_pll  = 1'b0;
    pgate    = 1'b0;
    pll_on   = 1'b1;
    osc_on   = 1'b1;
    rst_hold = 1'b0;
    case (state)
      ST_RUN:     clk_pll = pll_used;
      ST_AHB:     begin ahb_req = 1'b1; clk_pll = pll_used; end
      ST_AXI:     begin ahb_req = 1'b1; axi_req = 1'b1; clk_pll = pll_used; end
      ST_SREF:    begin ahb_req = 1'b1; axi_req = 1'b1; sref_req = 1'b1;
                        clk_pll = pll_used; end
      ST_CLKSW:   begin ahb_req = 1'b1; axi_req = 1'b1; sref_req = 1'b1; end
      ST_PGATE:   begin ahb_req = 1'b1; axi_req = 1'b1; sref_req = 1'b1;
                        pgate = deep; end
      ST_OFF:     begin ahb_req = 1'b1; axi_req = 1'b1; sref_req = 1'b1;
                        pgate = deep; pll_on = 1'b0; osc_on = 1'b0; end
      ST_W_OSC:   begin ahb_req = 1'b1; axi_req = 1'b1; sref_req = 1'b1;
                        pgate = deep; pll_on = 1'b0; rst_hold = deep; end
      ST_W_PWR:   begin ahb_req = 1'b1; axi_req = 1'b1; sref_req = 1'b1;
                        pll_on = 1'b0; rst_hold = deep; end
      ST_W_PLL:   begin ahb_req = 1'b1; axi_req = 1'b1; sref_req = 1'b1;
                        rst_hold = deep; end
      ST_RESTORE: begin clk_pll = pll_used; rst_hold = deep; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/lp_stop_seq.sv
module lp_stop_seq
  import lp_stop_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             wfi_i,
  input  logic             wake_i,
  input  logic             pll_in_use,
  input  logic [CNT_W-1:0] osc_wait,
  input  logic [CNT_W-1:0] pwr_wait,
  input  logic [CNT_W-1:0] lock_wait,
  output logic             ahb_drain_req,
  input  logic             ahb_drain_ack,
  output logic             axi_drain_req,
  input  logic             axi_drain_ack,
  output logic             sref_req,
  input  logic             sref_ack,
  output logic             clk_src_pll,
  output logic             pwr_gate,
  output logic             pll_en,
  output logic             osc_en,
  output logic             cpu_rst_hold
);
  localparam int SYNC_TOP = SYNC_STAGES - 1;

  // reset: asserted asynchronously, released through a short shift chain
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_TOP-1:0], 1'b1};
  end
  assign rst_i_n = sync_q[SYNC_TOP];

  seq_state_e       state_q, state_d;
  logic             deep_q, pll_used_q;
  logic             start, wake_go, pend, cnt_zero;
  logic             cnt_load, cnt_dec;
  logic [CNT_W-1:0] cnt_val;

  assign start   = (state_q == ST_RUN) && wfi_i &&
                   ((mode_sel == MODE_STOP) || (mode_sel == MODE_DEEP));
  assign wake_go = wake_i | pend;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:     if (start)         state_d = ST_AHB;
      ST_AHB:     if (ahb_drain_ack) state_d = ST_AXI;
      ST_AXI:     if (axi_drain_ack) state_d = ST_SREF;
      ST_SREF:    if (sref_ack)      state_d = ST_CLKSW;
      ST_CLKSW:   state_d = deep_q ? ST_PGATE : ST_OFF;
      ST_PGATE:   state_d = ST_OFF;
      ST_OFF:     if (wake_go)       state_d = ST_W_OSC;
      ST_W_OSC:   if (cnt_zero)      state_d = deep_q ? ST_W_PWR : ST_W_PLL;
      ST_W_PWR:   if (cnt_zero)      state_d = ST_W_PLL;
      ST_W_PLL:   if (cnt_zero)      state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_RUN;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   deep_q <= 1'b0;
    else if (start) deep_q <= (mode_sel == MODE_DEEP);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)                pll_used_q <= 1'b0;
    else if (state_q == ST_RUN)  pll_used_q <= pll_in_use;
  end

  // stabilisation counter shared by the three wake-up waits
  assign cnt_load = (state_d != state_q) && is_wait(state_d);
  assign cnt_dec  = is_wait(state_q) && !cnt_zero;

  always_comb begin
    case (state_d)
      ST_W_OSC: cnt_val = osc_wait;
      ST_W_PWR: cnt_val = pwr_wait;
      default:  cnt_val = lock_wait;
    endcase
  end

  lp_stop_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  lp_stop_wake u_wake (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set   (wake_i && is_entry(state_q)),
    .clr   (state_q == ST_OFF),
    .pend  (pend)
  );

  lp_stop_outdec u_dec (
    .state    (state_q),
    .deep     (deep_q),
    .pll_used (pll_used_q),
    .ahb_req  (ahb_drain_req),
    .axi_req  (axi_drain_req),
    .sref_req (sref_req),
    .clk_pll  (clk_src_pll),
    .pgate    (pwr_gate),
    .pll_on   (pll_en),
    .osc_on   (osc_en),
    .rst_hold (cpu_rst_hold)
  );
endmodule

// File: rtl/lp_stop_seq_chk.sv
module lp_stop_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       wfi_i,
  input logic       ahb_drain_req,
  input logic       ahb_drain_ack,
  input logic       axi_drain_req,
  input logic       axi_drain_ack,
  input logic       sref_req,
  input logic       sref_ack,
  input logic       clk_src_pll,
  input logic       pwr_gate,
  input logic       pll_en,
  input logic       osc_en,
  input logic       cpu_rst_hold
);
  p_ahb_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ahb_drain_req) |-> $past(wfi_i) &&
      (($past(mode_sel) == 2'b01) || ($past(mode_sel) == 2'b10)));

  p_axi_after_ahb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(axi_drain_req) |-> $past(ahb_drain_ack) && ahb_drain_req);

  p_sref_after_axi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sref_req) |-> $past(axi_drain_ack) && axi_drain_req);

  p_clk_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_src_pll) && sref_req) |-> $past(sref_ack));

  p_gate_in_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_gate |-> sref_req && !clk_src_pll);

  p_osc_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !pll_en && !clk_src_pll);

  p_pll_after_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(osc_en));

  p_hold_with_osc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_hold |-> osc_en);

  p_release_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst_hold) |-> !ahb_drain_req && $past(!ahb_drain_req));
endmodule

bind lp_stop_seq lp_stop_seq_chk u_chk (.*);

// File: tb/test_lp_stop_seq.sv
module test_lp_stop_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic        wfi_i, wake_i, pll_in_use;
  logic [15:0] osc_wait, pwr_wait, lock_wait;
  logic        ahb_drain_req, ahb_drain_ack, axi_drain_req, axi_drain_ack;
  logic        sref_req, sref_ack, clk_src_pll, pwr_gate, pll_en, osc_en, cpu_rst_hold;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lp_stop_seq i_lp_stop_seq (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic        pll;
    logic [15:0] osc;
    logic [15:0] pwr;
    logic [15:0] lock;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'b01, 1'b1, 16'd3,  16'd0, 16'd5},
    '{2'b10, 1'b1, 16'd2,  16'd4, 16'd6},
    '{2'b01, 1'b0, 16'd0,  16'd0, 16'd0},
    '{2'b10, 1'b0, 16'd0,  16'd0, 16'd0},
    '{2'b10, 1'b1, 16'd17, 16'd9, 16'd0},
    '{2'b01, 1'b1, 16'd0,  16'd7, 16'd12},
    '{2'b10, 1'b0, 16'd5,  16'd0, 16'd3},
    '{2'b01, 1'b0, 16'd40, 16'd3, 16'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_entry(input logic [1:0] m, input logic p, input logic [15:0] o,
                          input logic [15:0] w, input logic [15:0] l, input bit early);
    logic deep;
    deep = (m == 2'b10);
    mode_sel = m; pll_in_use = p; osc_wait = o; pwr_wait = w; lock_wait = l; wfi_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 clock follows pll use", clk_src_pll, p);
    chk("R2 idle before wfi", ahb_drain_req, 0);
    wfi_i = 1'b1;
    @(negedge clk);
    chk("R2 ahb request", ahb_drain_req, 1);
    chk("R3 axi waits for ahb ack", axi_drain_req, 0);
    repeat (2) @(negedge clk);
    chk("R3 axi held off", axi_drain_req, 0);
    ahb_drain_ack = 1'b1;
    @(negedge clk);
    ahb_drain_ack = 1'b0;
    chk("R3 axi request", axi_drain_req, 1);
    chk("R4 sref waits for axi ack", sref_req, 0);
    if (early) wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
    chk("R4 sref held off", sref_req, 0);
    axi_drain_ack = 1'b1;
    @(negedge clk);
    axi_drain_ack = 1'b0;
    chk("R4 sref request", sref_req, 1);
    chk("R5 clock kept during drain", clk_src_pll, p);
    @(negedge clk);
    chk("R5 clock kept awaiting sref", clk_src_pll, p);
    sref_ack = 1'b1;
    @(negedge clk);
    sref_ack = 1'b0;
    wfi_i = 1'b0;
    chk("R5 clock switched to osc", clk_src_pll, 0);
    chk("R6 pll on at switch", pll_en, 1);
    chk("R6 no gate at switch", pwr_gate, 0);
    if (deep) begin
      @(negedge clk);
      chk("R6 power gated", pwr_gate, 1);
      chk("R6 pll on while gating", pll_en, 1);
    end
    @(negedge clk);
    chk("R7 pll off", pll_en, 0);
    chk("R7 osc off", osc_en, 0);
    chk("R6 gate level when stopped", pwr_gate, deep);
  endtask

  task automatic do_wake(input bit drive, input logic p, input logic deep,
                         input logic [15:0] o, input logic [15:0] w, input logic [15:0] l);
    int n_o, n_p, n_l;
    bit done;
    n_o = 0; n_p = 0; n_l = 0; done = 0;
    if (drive) begin
      wake_i = 1'b1;
      @(negedge clk);
      wake_i = 1'b0;
    end else begin
      @(negedge clk);
    end
    chk("R8 osc enabled first", osc_en, 1);
    chk("R8 pll still off", pll_en, 0);
    chk("R9 reset hold on wake", cpu_rst_hold, deep);
    for (int i = 0; i < 3000 && !done; i++) begin
      if (!pll_en && osc_en && (!deep || pwr_gate)) n_o++;
      else if (!pll_en && osc_en) n_p++;
      else if (pll_en && ahb_drain_req) n_l++;
      else done = 1;
      if (!done) @(negedge clk);
    end
    chk("R8 oscillator wait length", n_o, o + 1);
    chk("R9 power wait length", n_p, deep ? w + 1 : 0);
    chk("R10 pll lock wait length", n_l, l + 1);
    chk("R10 clock restored", clk_src_pll, p);
    chk("R10 requests dropped", {ahb_drain_req, axi_drain_req, sref_req}, 0);
    chk("R10 reset still held in restore", cpu_rst_hold, deep);
    @(negedge clk);
    chk("R10 reset released last", cpu_rst_hold, 0);
    chk("R10 back to normal enables", {pll_en, osc_en, pwr_gate}, 3'b110);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; wfi_i = 1'b0; wake_i = 1'b0; pll_in_use = 1'b0;
    osc_wait = '0; pwr_wait = '0; lock_wait = '0;
    ahb_drain_ack = 1'b0; axi_drain_ack = 1'b0; sref_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset requests", {ahb_drain_req, axi_drain_req, sref_req}, 0);
    chk("R1 reset enables", {pll_en, osc_en}, 2'b11);
    chk("R1 reset gate hold clk", {pwr_gate, cpu_rst_hold, clk_src_pll}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset requests", ahb_drain_req, 0);

    // invalid modes ignore wfi
    mode_sel = 2'b00; wfi_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 mode 00 ignores wfi", ahb_drain_req, 0);
    mode_sel = 2'b11;
    repeat (4) @(negedge clk);
    chk("R2 mode 11 ignores wfi", ahb_drain_req, 0);
    wfi_i = 1'b0;

    // clock select tracks pll use in normal state
    pll_in_use = 1'b1;
    @(negedge clk);
    chk("R5 clock tracks pll use", clk_src_pll, 1);
    pll_in_use = 1'b0;
    @(negedge clk);
    chk("R5 clock tracks osc use", clk_src_pll, 0);

    // wake in normal state is ignored
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
    do_entry(2'b01, 1'b1, 16'd1, 16'd0, 16'd1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R11 normal-state wake ignored", osc_en, 0);
    do_wake(1'b1, 1'b1, 1'b0, 16'd1, 16'd0, 16'd1);

    // table of mode and wait combinations
    for (int i = 0; i < 8; i++) begin
      do_entry(VEC[i].mode, VEC[i].pll, VEC[i].osc, VEC[i].pwr, VEC[i].lock, 1'b0);
      repeat (3) @(negedge clk);
      chk("R7 stays stopped without wake", {pll_en, osc_en}, 0);
      do_wake(1'b1, VEC[i].pll, VEC[i].mode == 2'b10,
              VEC[i].osc, VEC[i].pwr, VEC[i].lock);
    end

    // wake during entry is latched (deep, then plain)
    do_entry(2'b10, 1'b1, 16'd2, 16'd3, 16'd2, 1'b1);
    do_wake(1'b0, 1'b1, 1'b1, 16'd2, 16'd3, 16'd2);
    do_entry(2'b01, 1'b0, 16'd4, 16'd0, 16'd1, 1'b1);
    do_wake(1'b0, 1'b0, 1'b0, 16'd4, 16'd0, 16'd1);

    // reset while stopped
    do_entry(2'b10, 1'b1, 16'd2, 16'd2, 16'd2, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset enables", {pll_en, osc_en}, 2'b11);
    chk("R1 async reset requests", {ahb_drain_req, axi_drain_req, sref_req}, 0);
    chk("R1 async reset gate", pwr_gate, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after mid-stop reset", {ahb_drain_req, cpu_rst_hold}, 0);

    summary();
    $finish;
  end
endmodule